// File: doc/BRIEF.md
# Banked CPU Address Decoder and Stretchable Processor Clock

This block sits between a 24-bit-address processor and the memories and peripherals of a character-cell display terminal. It runs entirely on the active dot clock. A modulo counter divides that clock by ten to make the processor clock, and the character clock for the CRT controller is the inverse of that clock. At the start of each processor cycle the block samples the address and the read/write line. It decodes them into exactly one chip select, which it holds for the whole cycle.

Slow devices get more time through a stretched cycle. The high phase is extended by one full divide period, so a stretched cycle lasts twenty dot clocks and an ordinary one lasts ten. The peripheral register windows are always stretched. The ROM banks and the CRT controller window are stretched only when the column-mode input selects the wide (132-column) format. Write strobes for the screen, attribute and character generator memories are active only in the low phase of the cycle. The upper display memory address bit comes from a page control bit and not from the CPU address.

Top module: `bus_decode_clkgen`

## Requirements
- R1: While `rst` is high at a dot clock edge, all chip selects and write strobes are 0, `cpu_clk` is 0, `crtc_cclk` is 1 and `disp_a14` is 0.
- R2: A cycle whose starting address lies in bank 0 (address bits 23:16 equal to 0) asserts exactly one chip select for the whole cycle, chosen by address bits 15:13: 0 system RAM, 1 CRT controller, 2 gate-array registers/character generator, 3 communication ports. Address changes during a cycle do not affect it.
- R3: In bank 0, addresses 0x8000–0xBFFF select screen RAM and 0xC000–0xFFFF select attribute RAM.
- R4: Read cycles in bank 1 assert `cs_rom_lo` and read cycles in bank 3 assert `cs_rom_hi`. Write cycles to either ROM bank, and any cycle in another non-zero bank, assert no chip select and are not stretched.
- R5: An unstretched processor cycle is 10 dot clocks long, with `cpu_clk` high for the first 5 and low for the last 5. The first cycle begins at the first edge after reset is released.
- R6: `crtc_cclk` is the complement of `cpu_clk` at every dot clock edge.
- R7: When `col132` is 1 at the start of a cycle, a ROM read cycle or a CRT controller cycle lasts 20 dot clocks, with `cpu_clk` high for 15 and low for 5.
- R8: Cycles to the gate-array or communication windows are stretched to 20 dot clocks whatever the value of `col132`. ROM and CRT controller cycles with `col132` at 0, and cycles to every other region, are not stretched.
- R9: `we_screen`, `we_attr` and `we_cgen` (the last for gate-array window writes) go high only during the low phase of a write cycle (`cpu_rnw` 0 at cycle start) to their region. At most one of them is high at a time, and none is high on a read.
- R10: `disp_a14` equals the value `page_bit` had at the previous dot clock edge, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dot_clk | input | 1 | Active dot clock; the only clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 24 | Processor address (bank in bits 23:16) |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| col132 | input | 1 | Wide-format (132-column) mode |
| page_bit | input | 1 | Display memory page control bit |
| cs_sysram | output | 1 | System RAM select |
| cs_crtc | output | 1 | CRT controller select |
| cs_gate | output | 1 | Gate-array registers / character generator select |
| cs_comm | output | 1 | Communication ports select |
| cs_screen | output | 1 | Screen (character) RAM select |
| cs_attr | output | 1 | Attribute RAM select |
| cs_rom_lo | output | 1 | ROM in bank 1 select |
| cs_rom_hi | output | 1 | ROM in bank 3 select |
| we_screen | output | 1 | Screen RAM write strobe |
| we_attr | output | 1 | Attribute RAM write strobe |
| we_cgen | output | 1 | Character generator write strobe |
| cpu_clk | output | 1 | Processor clock (dot clock / 10, stretchable) |
| crtc_cclk | output | 1 | Inverted processor clock for the CRT controller |
| disp_a14 | output | 1 | Display memory address bit 14 |

## Verification
The bench attacks the stretch decision in both column modes and for every region. A design that stretched ROM in narrow mode, or failed to stretch the peripheral windows in narrow mode, would show a 15-dot high phase where 5 is due, or the reverse. Addresses change in the middle of cycles and at odd phases. A decoder that followed the live address instead of the one latched at cycle start would switch chip selects mid-cycle. Writes to ROM banks and to unmapped or boundary addresses (0x1FFFF, 0x20000, 0x3FFFFF) check that a write selects no ROM, adds no stretch, and that strobes never show up in the high phase or on reads.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  // Region codes; value minus one is the chip-select bit index.
  typedef enum logic [3:0] {
    RG_NONE   = 4'd0,
    RG_SYSRAM = 4'd1,
    RG_CRTC   = 4'd2,
    RG_GATE   = 4'd3,
    RG_COMM   = 4'd4,
    RG_SCREEN = 4'd5,
    RG_ATTR   = 4'd6,
    RG_ROM_LO = 4'd7,
    RG_ROM_HI = 4'd8
  } region_e;

  localparam int NUM_CS = 8;

  // Peripheral register windows: stretched in every column mode.
  function automatic logic is_io(region_e r);
    return (r == RG_GATE) || (r == RG_COMM);
  endfunction

  // Devices that are slow only at the wide-format clock rate.
  function automatic logic is_wide_slow(region_e r);
    return (r == RG_ROM_LO) || (r == RG_ROM_HI) || (r == RG_CRTC);
  endfunction

endpackage

// File: rtl/addr_map.sv
module addr_map
  import busdec_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ROM_LO_BANK = 1,
  parameter int ROM_HI_BANK = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rnw,
  output region_e           region
);

  localparam int BANK_W = ADDR_W - 16;

  logic [BANK_W-1:0] bank;
  logic [2:0]        blk8k;

  assign bank  = addr[ADDR_W-1:16];
  assign blk8k = addr[15:13];

  always_comb begin
    region = RG_NONE;
    if (bank == '0) begin
      unique case (blk8k)
        3'd0:       region = RG_SYSRAM;
        3'd1:       region = RG_CRTC;
        3'd2:       region = RG_GATE;
        3'd3:       region = RG_COMM;
        3'd4, 3'd5: region = RG_SCREEN;
        default:    region = RG_ATTR;
      endcase
    end else if (rnw && bank == BANK_W'(ROM_LO_BANK)) begin
      region = RG_ROM_LO;
    end else if (rnw && bank == BANK_W'(ROM_HI_BANK)) begin
      region = RG_ROM_HI;
    end
  end

endmodule

// File: rtl/stretch_seq.sv
module stretch_seq
  import busdec_pkg::*;
#(
  parameter int DIV = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  region_e region_in,
  input  logic    rnw_in,
  input  logic    wide,
  output region_e cyc_region,
  output logic    cyc_wr,
  output logic    lo_phase
);

  localparam int LEN_SHORT = DIV;
  localparam int LEN_LONG  = 2 * DIV;
  localparam int HI_SHORT  = DIV / 2;
  localparam int HI_LONG   = DIV / 2 + DIV;
  localparam int CW        = $clog2(LEN_LONG);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          long_q, long_n;
  region_e       reg_n;
  logic          wr_n, lo_n, wrap, need;

  assign need = is_io(region_in) || (wide && is_wide_slow(region_in));
  assign wrap = long_q ? (cnt_q == CW'(LEN_LONG - 1)) : (cnt_q == CW'(LEN_SHORT - 1));

  always_comb begin
    cnt_n  = CW'(cnt_q + 1'b1);
    long_n = long_q;
    reg_n  = cyc_region;
    wr_n   = cyc_wr;
    if (wrap) begin
      cnt_n  = '0;
      long_n = need;
      reg_n  = region_in;
      wr_n   = !rnw_in;
    end
    lo_n = long_n ? (cnt_n >= CW'(HI_LONG)) : (cnt_n >= CW'(HI_SHORT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= CW'(LEN_SHORT - 1);
      long_q     <= 1'b0;
      cyc_region <= RG_NONE;
      cyc_wr     <= 1'b0;
      lo_phase   <= 1'b1;
    end else begin
      cnt_q      <= cnt_n;
      long_q     <= long_n;
      cyc_region <= reg_n;
      cyc_wr     <= wr_n;
      lo_phase   <= lo_n;
    end
  end

  // A stretched cycle may only be running for a slow device class.
  AST_STRETCH_CLASS: assert property (@(posedge clk) disable iff (rst)
    long_q |-> (is_io(cyc_region) || is_wide_slow(cyc_region))); // R8

endmodule

// File: rtl/bus_decode_clkgen.sv
module bus_decode_clkgen
  import busdec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIV    = 10
) (
  input  logic              dot_clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic              col132,
  input  logic              page_bit,
  output logic              cs_sysram,
  output logic              cs_crtc,
  output logic              cs_gate,
  output logic              cs_comm,
  output logic              cs_screen,
  output logic              cs_attr,
  output logic              cs_rom_lo,
  output logic              cs_rom_hi,
  output logic              we_screen,
  output logic              we_attr,
  output logic              we_cgen,
  output logic              cpu_clk,
  output logic              crtc_cclk,
  output logic              disp_a14
);

  region_e           dec_region, cyc_region;
  logic              cyc_wr, lo_phase;
  logic [NUM_CS-1:0] cs_vec;

  addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr   (cpu_addr),
    .rnw    (cpu_rnw),
    .region (dec_region)
  );

  stretch_seq #(.DIV(DIV)) u_seq (
    .clk        (dot_clk),
    .rst        (rst),
    .region_in  (dec_region),
    .rnw_in     (cpu_rnw),
    .wide       (col132),
    .cyc_region (cyc_region),
    .cyc_wr     (cyc_wr),
    .lo_phase   (lo_phase)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_vec[i] = (cyc_region == region_e'(4'(i + 1)));
  end

  assign cs_sysram = cs_vec[RG_SYSRAM - 1];
  assign cs_crtc   = cs_vec[RG_CRTC - 1];
  assign cs_gate   = cs_vec[RG_GATE - 1];
  assign cs_comm   = cs_vec[RG_COMM - 1];
  assign cs_screen = cs_vec[RG_SCREEN - 1];
  assign cs_attr   = cs_vec[RG_ATTR - 1];
  assign cs_rom_lo = cs_vec[RG_ROM_LO - 1];
  assign cs_rom_hi = cs_vec[RG_ROM_HI - 1];

  assign we_screen = lo_phase && cyc_wr && cs_screen;
  assign we_attr   = lo_phase && cyc_wr && cs_attr;
  assign we_cgen   = lo_phase && cyc_wr && cs_gate;

  assign cpu_clk   = !lo_phase;
  assign crtc_cclk = lo_phase;

  always_ff @(posedge dot_clk) begin
    if (rst) disp_a14 <= 1'b0;
    else     disp_a14 <= page_bit;
  end

  AST_CS_ONEHOT: assert property (@(posedge dot_clk) disable iff (rst)
    $onehot0(cs_vec)); // R2

  AST_CS_HOLD: assert property (@(posedge dot_clk) disable iff (rst)
    !$rose(cpu_clk) |-> $stable(cs_vec)); // R2

  AST_ROM_READ_ONLY: assert property (@(posedge dot_clk) disable iff (rst)
    (cs_rom_lo || cs_rom_hi) |-> !cyc_wr); // R4

  AST_WE_LOW_PHASE: assert property (@(posedge dot_clk) disable iff (rst)
    (we_screen || we_attr || we_cgen) |-> !cpu_clk); // R9

  AST_WE_SINGLE: assert property (@(posedge dot_clk) disable iff (rst)
    $onehot0({we_screen, we_attr, we_cgen})); // R9

endmodule

// File: tb/test_bus_decode_clkgen.sv
module test_bus_decode_clkgen;

  localparam int DIV = 10;

  logic        dot_clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cpu_addr = '0;
  logic        cpu_rnw = 1'b1;
  logic        col132 = 1'b0;
  logic        page_bit = 1'b0;
  logic cs_sysram, cs_crtc, cs_gate, cs_comm, cs_screen, cs_attr, cs_rom_lo, cs_rom_hi;
  logic we_screen, we_attr, we_cgen, cpu_clk, crtc_cclk, disp_a14;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 dot_clk = ~dot_clk;

  bus_decode_clkgen #(.ADDR_W(24), .DIV(DIV)) i_bus_decode_clkgen (
    .dot_clk, .rst, .cpu_addr, .cpu_rnw, .col132, .page_bit,
    .cs_sysram, .cs_crtc, .cs_gate, .cs_comm, .cs_screen, .cs_attr,
    .cs_rom_lo, .cs_rom_hi, .we_screen, .we_attr, .we_cgen,
    .cpu_clk, .crtc_cclk, .disp_a14
  );

  // Reference model: position within a cycle and cycle length.
  int m_pos, m_len, m_reg;
  bit m_wr, m_a14;

  // Codes: 1 sysram, 2 crtc, 3 gate, 4 comm, 5 screen, 6 attr, 7 rom lo, 8 rom hi.
  function automatic int ref_region(input logic [23:0] a, input logic rd);
    int v = int'(a);
    if (v < 'h2000)       return 1;
    else if (v < 'h4000)  return 2;
    else if (v < 'h6000)  return 3;
    else if (v < 'h8000)  return 4;
    else if (v < 'hC000)  return 5;
    else if (v < 'h10000) return 6;
    else if (v >= 'h10000 && v < 'h20000) return rd ? 7 : 0;
    else if (v >= 'h30000 && v < 'h40000) return rd ? 8 : 0;
    return 0;
  endfunction

  function automatic bit ref_slow(input int r, input bit wide);
    if (r == 3 || r == 4) return 1;
    if (wide && (r == 2 || r == 7 || r == 8)) return 1;
    return 0;
  endfunction

  always @(posedge dot_clk) begin
    if (rst) begin
      m_pos = DIV - 1; m_len = DIV; m_reg = 0; m_wr = 0; m_a14 = 0;
    end else begin
      m_a14 = page_bit;
      m_pos = m_pos + 1;
      if (m_pos == m_len) begin
        m_pos = 0;
        m_reg = ref_region(cpu_addr, cpu_rnw);
        m_wr  = !cpu_rnw;
        m_len = ref_slow(m_reg, col132) ? 2 * DIV : DIV;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] cs_act, cs_exp;
    logic [2:0] we_act, we_exp;
    bit clk_exp;
    cs_act = {cs_rom_hi, cs_rom_lo, cs_attr, cs_screen, cs_comm, cs_gate, cs_crtc, cs_sysram};
    cs_exp = (m_reg == 0) ? 8'h00 : 8'(1 << (m_reg - 1));
    clk_exp = (m_pos < m_len - DIV / 2);
    we_exp = 3'b000;
    if (!clk_exp && m_wr) begin
      if (m_reg == 5) we_exp = 3'b001;
      if (m_reg == 6) we_exp = 3'b010;
      if (m_reg == 3) we_exp = 3'b100;
    end
    we_act = {we_cgen, we_attr, we_screen};
    chk(cs_act === cs_exp, "R2 R3 R4 chip selects", 32'(cs_act), 32'(cs_exp));
    chk(cpu_clk === clk_exp, "R5 R7 R8 cpu_clk", 32'(cpu_clk), 32'(clk_exp));
    chk(crtc_cclk === !clk_exp, "R6 crtc_cclk", 32'(crtc_cclk), 32'(!clk_exp));
    chk(we_act === we_exp, "R9 write strobes", 32'(we_act), 32'(we_exp));
    chk(disp_a14 === m_a14, "R10 disp_a14", 32'(disp_a14), 32'(m_a14));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  localparam logic [23:0] AV [15] = '{
    24'h001234, 24'h002000, 24'h005FFF, 24'h006ABC, 24'h008000,
    24'h00BFFF, 24'h00C000, 24'h00FFFF, 24'h010000, 24'h01FFFF,
    24'h020000, 24'h030010, 24'h03FFFF, 24'h3FFFFF, 24'hFF0000
  };

  initial begin
    int tick = 0;
    repeat (3) @(posedge dot_clk);
    @(negedge dot_clk);
    // R1: reset values
    chk({cs_sysram, cs_crtc, cs_gate, cs_comm, cs_screen, cs_attr, cs_rom_lo, cs_rom_hi} === 8'h00,
        "R1 chip selects in reset", 32'({cs_sysram, cs_crtc, cs_gate, cs_comm}), 32'h0);
    chk({we_screen, we_attr, we_cgen} === 3'b000, "R1 strobes in reset",
        32'({we_screen, we_attr, we_cgen}), 32'h0);
    chk(cpu_clk === 1'b0 && crtc_cclk === 1'b1, "R1 clocks in reset",
        32'({cpu_clk, crtc_cclk}), 32'h1);
    chk(disp_a14 === 1'b0, "R1 disp_a14 in reset", 32'(disp_a14), 32'h0);
    rst = 1'b0;
    for (int w = 0; w < 2; w++) begin
      for (int rd = 1; rd >= 0; rd--) begin
        for (int i = 0; i < 15; i++) begin
          cpu_addr = AV[i];
          cpu_rnw  = rd[0];
          col132   = w[0];
          for (int c = 0; c < 17 + (i % 5) * 3; c++) begin
            @(negedge dot_clk);
            compare_all();
            tick++;
            if (tick % 7 == 0) page_bit = ~page_bit;
            // R2: mid-cycle address wiggle must not disturb the held selects
            if (c == 3) cpu_addr = AV[(i + 4) % 15];
            if (c == 5) cpu_addr = AV[i];
          end
        end
      end
    end
    done = 1;
    finish_run();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      finish_run();
    end
  end

endmodule